// File: doc/BRIEF.md
# Lockable Group Control and Status Registers

This block is the register front end of a save/restore controller. It holds one control word per descriptor group, a global control word and an interrupt status word. Software reaches all of them through a single-cycle register port. Every access carries the ID of the domain that issues it. The group enables, the hardware-request disable and a one-cycle soft reset pulse drive the engine. The engine reports its events back as flag pulses, together with a descriptor index.

Each group has three sticky protection bits. A domain lock restricts the group to its owning domain. A write lock rejects every write to the group. A read lock hides the group from every read. Once software sets one of these bits, only the hardware reset clears it. An access that a lock rejects has no effect on any register. Such an access returns zero and raises a violation pulse.

Four of the five status flags are cleared by writing 1 to them. The flag that marks completion of a software request is cleared only by a soft reset or a hardware reset.

Top module: `lkgrp_regs`

## Requirements
- R1: After the hardware reset `rst_n` is released, every register reads 0, `acc_viol` is 0, `grp_en_o` is 0, `hw_req_dis_o` is 0 and `sw_rst_o` is 0.
- R2: Group g sits at word address 8+g. In its control word, bit 0 is the enable and drives `grp_en_o[g]`, and bits 11:8 hold the owning domain. Other unlisted bits read 0.
- R3: The group word has three lock bits: bit 1 is the domain lock, bit 2 the write lock and bit 3 the read lock. Writing 1 sets a lock bit. Writing 0 leaves it unchanged. A soft reset does not clear it. Only `rst_n` clears it.
- R4: When the domain lock of a group is set, an access to that group from a domain other than the owner is rejected. A rejected read returns 0. A rejected write leaves the word unchanged. Either one raises `acc_viol`.
- R5: When the write lock of a group is set, every write to that group is dropped and raises `acc_viol`, whatever its domain. Reads of the group are still allowed.
- R6: When the read lock of a group is set, every read of that group returns 0 and raises `acc_viol`. Writes to the group are still allowed.
- R7: The status word is at address 1. Its bits are: bit 0 address error, bit 1 bus error, bit 2 software-request done, bit 3 timeout, bit 4 group conflict. The error index is in bits 16 upward. A 1 on `evt_flags_i[k]` sets flag k at the next clock edge. An address error or a bus error event also loads `evt_idx_i` into the error index.
- R8: Writing 1 to status bits 0, 1, 3 or 4 clears those bits. A write never changes bit 2.
- R9: The global control word is at address 0. Bit 1 is the hardware-request disable and drives `hw_req_dis_o`. Writing 1 to bit 0 raises `sw_rst_o` for exactly one cycle, starting at the clock edge of the write. Bit 0 always reads 0.
- R10: The soft reset clears the status flags, the error index, the hardware-request disable and all group enables. The owner domains and the lock bits are kept.
- R11: Read data and `acc_viol` are registered: they reflect an access at the clock edge that samples it, and they are 0 in cycles without an access. A read of an unmapped address returns 0 without a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| acc_en | input | 1 | Register access request, one access per cycle |
| acc_wr | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | ADDR_W | Word address |
| acc_wdata | input | DW | Write data |
| acc_dom | input | DOM_W | Domain ID of the access |
| acc_rdata | output | DW | Registered read data |
| acc_viol | output | 1 | One-cycle pulse for a rejected access |
| grp_en_o | output | NG | Per-group enable |
| hw_req_dis_o | output | 1 | Hardware save/restore requests disabled |
| sw_rst_o | output | 1 | One-cycle soft reset pulse |
| evt_flags_i | input | 5 | Engine event pulses, one per status flag |
| evt_idx_i | input | IDX_W | Descriptor index that goes with an error event |

## Verification
The assertions assume the following about the inputs:
- At most one access is presented per cycle.
- No access is presented in the cycle in which the soft reset pulse is high, because the reset takes priority over that access.
- Event pulses that arrive while the soft reset is applied are lost.

The bench follows these rules. Accesses come from one task, each lasting one clock edge. After a soft reset write, the bench waits out the pulse before the next access. Event pulses are driven only between accesses. Lock bits are masked off in the random phase, so random traffic does not freeze every group early. Locks are then set in directed steps, each step targeting a known group and domain.

// File: rtl/lkgrp_regs.sv
module lkgrp_regs #(
  parameter int NG     = 4,
  parameter int DOM_W  = 4,
  parameter int IDX_W  = 10,
  parameter int ADDR_W = 6,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DW-1:0]     acc_wdata,
  input  logic [DOM_W-1:0]  acc_dom,
  output logic [DW-1:0]     acc_rdata,
  output logic              acc_viol,
  output logic [NG-1:0]     grp_en_o,
  output logic              hw_req_dis_o,
  output logic              sw_rst_o,
  input  logic [4:0]        evt_flags_i,
  input  logic [IDX_W-1:0]  evt_idx_i
);
  localparam int GW       = (NG > 1) ? $clog2(NG) : 1;
  localparam int A_CTRL   = 0;
  localparam int A_STAT   = 1;
  localparam int GRP_BASE = 8;
  localparam int OWN_LSB  = 8;
  localparam int IDX_LSB  = 16;
  localparam logic [4:0] W1C_MASK = 5'b11011;

  logic             en_q [NG];
  logic             dlk_q [NG];
  logic             wlk_q [NG];
  logic             rlk_q [NG];
  logic [DOM_W-1:0] own_q [NG];
  logic [NG-1:0]    dl_v, wl_v, rl_v;
  logic [4:0]       st_q;
  logic [IDX_W-1:0] idx_q;
  logic             hwdis_q, srst_q;

  logic          hit_grp;
  logic [GW-1:0] gsel;
  logic          dom_blk, wr_blk, rd_blk, do_wr, do_rd;
  logic [DW-1:0] grp_word, rd_mux;

  always_comb begin
    hit_grp = 1'b0;
    gsel    = '0;
    for (int g = 0; g < NG; g++)
      if (acc_addr == ADDR_W'(GRP_BASE + g)) begin
        hit_grp = 1'b1;
        gsel    = GW'(g);
      end
  end

  assign dom_blk = hit_grp && dlk_q[gsel] && (acc_dom != own_q[gsel]);
  assign wr_blk  = dom_blk || (hit_grp && wlk_q[gsel]);
  assign rd_blk  = dom_blk || (hit_grp && rlk_q[gsel]);
  assign do_wr   = acc_en && acc_wr;
  assign do_rd   = acc_en && !acc_wr;

  always_comb begin
    grp_word = '0;
    grp_word[0] = en_q[gsel];
    grp_word[1] = dlk_q[gsel];
    grp_word[2] = wlk_q[gsel];
    grp_word[3] = rlk_q[gsel];
    grp_word[OWN_LSB +: DOM_W] = own_q[gsel];
    rd_mux = '0;
    if (acc_addr == ADDR_W'(A_CTRL)) rd_mux[1] = hwdis_q;
    else if (acc_addr == ADDR_W'(A_STAT)) begin
      rd_mux[4:0] = st_q;
      rd_mux[IDX_LSB +: IDX_W] = idx_q;
    end else if (hit_grp) rd_mux = grp_word;
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic wsel;
    assign wsel = do_wr && hit_grp && (gsel == GW'(g)) && !wr_blk;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[g]  <= 1'b0;
        dlk_q[g] <= 1'b0;
        wlk_q[g] <= 1'b0;
        rlk_q[g] <= 1'b0;
        own_q[g] <= '0;
      end else if (srst_q) begin
        en_q[g]  <= 1'b0;
      end else if (wsel) begin
        en_q[g]  <= acc_wdata[0];
        dlk_q[g] <= dlk_q[g] | acc_wdata[1];
        wlk_q[g] <= wlk_q[g] | acc_wdata[2];
        rlk_q[g] <= rlk_q[g] | acc_wdata[3];
        own_q[g] <= acc_wdata[OWN_LSB +: DOM_W];
      end
    end
    assign grp_en_o[g] = en_q[g];
    assign dl_v[g]     = dlk_q[g];
    assign wl_v[g]     = wlk_q[g];
    assign rl_v[g]     = rlk_q[g];
  end

  logic ctrl_wr, stat_wr;
  assign ctrl_wr = do_wr && (acc_addr == ADDR_W'(A_CTRL));
  assign stat_wr = do_wr && (acc_addr == ADDR_W'(A_STAT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= '0;
      idx_q   <= '0;
      hwdis_q <= 1'b0;
      srst_q  <= 1'b0;
    end else begin
      srst_q <= ctrl_wr && acc_wdata[0] && !srst_q;
      if (srst_q) begin
        st_q    <= '0;
        idx_q   <= '0;
        hwdis_q <= 1'b0;
      end else begin
        st_q <= (st_q & ~(stat_wr ? (acc_wdata[4:0] & W1C_MASK) : 5'b0)) | evt_flags_i;
        if (evt_flags_i[0] || evt_flags_i[1]) idx_q <= evt_idx_i;
        if (ctrl_wr) hwdis_q <= acc_wdata[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_rdata <= '0;
      acc_viol  <= 1'b0;
    end else begin
      acc_rdata <= (do_rd && !rd_blk) ? rd_mux : '0;
      acc_viol  <= acc_en && (acc_wr ? wr_blk : rd_blk);
    end
  end

  assign hw_req_dis_o = hwdis_q;
  assign sw_rst_o     = srst_q;
endmodule

// File: rtl/lkgrp_regs_chk.sv
module lkgrp_regs_chk #(
  parameter int NG    = 4,
  parameter int DW    = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_en,
  input logic          acc_wr,
  input logic          acc_viol,
  input logic [DW-1:0] acc_rdata,
  input logic          srst,
  input logic [4:0]    st,
  input logic          hwdis,
  input logic [4:0]    evt,
  input logic [NG-1:0] dl,
  input logic [NG-1:0] wl,
  input logic [NG-1:0] rl
);
  assert_dlock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(dl) & ~dl) == '0));
  assert_wlock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(wl) & ~wl) == '0));
  assert_rlock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(rl) & ~rl) == '0));
  assert_blocked_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_viol && !$past(acc_wr)) |-> (acc_rdata == '0));
  assert_evt_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != 5'b0 && !srst) |=> ((st & $past(evt)) == $past(evt)));
  assert_done_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st[2] && !srst) |=> st[2]);
  assert_srst_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !srst);
  assert_srst_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (st == 5'b0 && !hwdis));
  assert_viol_needs_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_viol |-> $past(acc_en));
endmodule

bind lkgrp_regs lkgrp_regs_chk #(.NG(NG), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
  .acc_viol(acc_viol), .acc_rdata(acc_rdata), .srst(srst_q), .st(st_q),
  .hwdis(hwdis_q), .evt(evt_flags_i), .dl(dl_v), .wl(wl_v), .rl(rl_v)
);

// File: tb/tb_lkgrp_regs.sv
`timescale 1ns/100ps
module tb_lkgrp_regs;
  localparam int NG = 4;
  logic clk = 0, rst_n = 0;
  logic acc_en = 0, acc_wr = 0;
  logic [5:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [3:0] acc_dom = '0;
  logic [31:0] acc_rdata;
  logic acc_viol;
  logic [NG-1:0] grp_en_o;
  logic hw_req_dis_o, sw_rst_o;
  logic [4:0] evt_flags_i = '0;
  logic [9:0] evt_idx_i = '0;

  lkgrp_regs dut (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit m_en[NG], m_dl[NG], m_wl[NG], m_rl[NG];
  logic [3:0] m_own[NG];
  logic [4:0] m_st;
  logic [9:0] m_idx;
  bit m_hw;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_grp(int g);
    return {20'b0, m_own[g], 4'b0, m_rl[g], m_wl[g], m_dl[g], m_en[g]};
  endfunction
  function automatic bit dom_blk(int g, logic [3:0] d);
    return m_dl[g] && d != m_own[g];
  endfunction
  function automatic logic [NG-1:0] exp_en();
    logic [NG-1:0] v;
    for (int g = 0; g < NG; g++) v[g] = m_en[g];
    return v;
  endfunction

  task automatic acc(input bit wr, input logic [5:0] a, input logic [31:0] d,
                     input logic [3:0] dom, output logic [31:0] rd, output logic v);
    @(negedge clk);
    acc_en = 1; acc_wr = wr; acc_addr = a; acc_wdata = d; acc_dom = dom;
    @(posedge clk); #1;
    rd = acc_rdata; v = acc_viol;
    acc_en = 0;
  endtask

  task automatic grp_wr(input int g, input logic [31:0] d, input logic [3:0] dom, input string req);
    logic [31:0] rd; logic v; bit blk;
    blk = dom_blk(g, dom) || m_wl[g];
    acc(1, 6'(8 + g), d, dom, rd, v);
    chk(req, {31'b0, v}, {31'b0, blk});
    if (!blk) begin
      m_en[g] = d[0]; m_dl[g] |= d[1]; m_wl[g] |= d[2]; m_rl[g] |= d[3]; m_own[g] = d[11:8];
    end
  endtask

  task automatic grp_rd(input int g, input logic [3:0] dom, input string req);
    logic [31:0] rd; logic v; bit blk;
    blk = dom_blk(g, dom) || m_rl[g];
    acc(0, 6'(8 + g), 0, dom, rd, v);
    chk(req, {31'b0, v}, {31'b0, blk});
    chk(req, rd, blk ? 32'h0 : exp_grp(g));
  endtask

  task automatic stat_rd(input string req);
    logic [31:0] rd; logic v;
    acc(0, 6'd1, 0, 0, rd, v);
    chk(req, rd, {6'b0, m_idx, 11'b0, m_st});
  endtask

  task automatic evt(input logic [4:0] f, input logic [9:0] i);
    @(negedge clk); evt_flags_i = f; evt_idx_i = i;
    @(posedge clk); #1; evt_flags_i = 0;
    m_st |= f;
    if (f[0] || f[1]) m_idx = i;
  endtask

  task automatic soft_rst(input string req);
    logic [31:0] rd; logic v;
    acc(1, 6'd0, 32'h1, 0, rd, v);
    chk(req, {31'b0, sw_rst_o}, 32'h1);
    @(posedge clk); #1;
    chk(req, {31'b0, sw_rst_o}, 32'h0);
    m_st = 0; m_idx = 0; m_hw = 0;
    for (int g = 0; g < NG; g++) m_en[g] = 0;
  endtask

  task automatic model_clear();
    for (int g = 0; g < NG; g++) begin
      m_en[g] = 0; m_dl[g] = 0; m_wl[g] = 0; m_rl[g] = 0; m_own[g] = 0;
    end
    m_st = 0; m_idx = 0; m_hw = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd; logic v;
    void'($urandom(32'd1234));
    model_clear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1 viol", {31'b0, acc_viol}, 0);
    chk("R1 outputs", {29'b0, grp_en_o[0], hw_req_dis_o, sw_rst_o}, 0);
    acc(0, 6'd0, 0, 0, rd, v); chk("R1 ctrl", rd, 0);
    stat_rd("R1 status");
    for (int g = 0; g < NG; g++) grp_rd(g, 0, "R1 group");
    // R11 unmapped
    acc(0, 6'd5, 0, 0, rd, v);
    chk("R11 unmapped data", rd, 0); chk("R11 unmapped viol", {31'b0, v}, 0);
    @(posedge clk); #1 chk("R11 idle viol", {31'b0, acc_viol}, 0);
    chk("R11 idle data", acc_rdata, 0);

    // random phase, no locks
    for (int n = 0; n < 400; n++) begin
      int op; int g; logic [31:0] d;
      op = $urandom_range(0, 6); g = $urandom_range(0, NG - 1); d = $urandom();
      case (op)
        0, 1: begin grp_wr(g, d & 32'hFFFF_FFF1, 4'($urandom()), "R2 write");
                    chk("R2 enable out", {28'b0, grp_en_o}, {28'b0, exp_en()}); end
        2: grp_rd(g, 4'($urandom()), "R2 readback");
        3: begin evt(5'($urandom()), 10'($urandom())); stat_rd("R7 status"); end
        4: begin acc(1, 6'd1, d, 0, rd, v); m_st &= ~(d[4:0] & 5'b11011); stat_rd("R8 w1c"); end
        5: begin acc(1, 6'd0, d & 32'hFFFF_FFFE, 0, rd, v); m_hw = d[1];
                 chk("R9 hw disable", {31'b0, hw_req_dis_o}, {31'b0, m_hw});
                 acc(0, 6'd0, 0, 0, rd, v); chk("R9 ctrl read", rd, {30'b0, m_hw, 1'b0}); end
        default: stat_rd("R7 status idle");
      endcase
    end

    // R8 done flag is not write-clearable
    evt(5'b11111, 10'h2A5);
    acc(1, 6'd1, 32'h1F, 0, rd, v); m_st = 5'b00100;
    stat_rd("R8 done kept");

    // R9 R10 soft reset
    grp_wr(0, 32'h0000_0501, 4'd5, "R10 setup");
    acc(1, 6'd0, 32'h2, 0, rd, v); m_hw = 1;
    soft_rst("R9 pulse");
    stat_rd("R10 status cleared");
    chk("R10 hw disable", {31'b0, hw_req_dis_o}, 0);
    chk("R10 enables", {28'b0, grp_en_o}, 0);
    grp_rd(0, 4'd5, "R10 owner kept");

    // R4 domain lock on group 0
    grp_wr(0, 32'h0000_0303, 4'd3, "R4 set");
    grp_rd(0, 4'd5, "R4 foreign read");
    grp_wr(0, 32'h0000_0500, 4'd5, "R4 foreign write");
    grp_rd(0, 4'd3, "R4 owner read");
    grp_wr(0, 32'h0000_0300, 4'd3, "R3 zero keeps lock");
    grp_rd(0, 4'd3, "R3 lock held");

    // R5 write lock on group 1
    grp_wr(1, 32'h0000_0205, 4'd2, "R5 set");
    grp_wr(1, 32'h0000_0200, 4'd2, "R5 owner write dropped");
    grp_rd(1, 4'd9, "R5 read allowed");
    chk("R5 enable held", {31'b0, grp_en_o[1]}, 1);

    // R6 read lock on group 2
    grp_wr(2, 32'h0000_0109, 4'd1, "R6 set");
    grp_rd(2, 4'd1, "R6 read blocked");
    grp_wr(2, 32'h0000_0100, 4'd1, "R6 write allowed");
    chk("R6 enable out", {31'b0, grp_en_o[2]}, 0);

    // R3 soft reset keeps locks, hardware reset clears them
    soft_rst("R3 soft reset");
    grp_rd(1, 4'd0, "R3 wlock after soft reset");
    grp_rd(0, 4'd3, "R3 dlock after soft reset");
    @(negedge clk) rst_n = 0;
    @(negedge clk) rst_n = 1;
    model_clear();
    for (int g = 0; g < NG; g++) grp_rd(g, 4'd7, "R3 hardware reset clears");
    grp_wr(1, 32'h0000_0001, 4'd7, "R3 write after reset");
    chk("R3 enable after reset", {31'b0, grp_en_o[1]}, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule